// File: doc/BRIEF.md
# Deferred-Update Four-Channel DAC Register Block

This block sits between a 16-bit host register bus and four 12-bit digital-to-analog converters. Each channel owns a write-only preload register, and a shared range register holds one polarity select and one gain select per channel. Two host reads act as commit strobes instead of returning data. Reading the range register copies the staged range bits to the converter selects. Reading the second control register copies all four preload codes to the converter inputs in the same cycle, so the four outputs change together.

A control word holds a global converter enable and a deferred-update flag. With deferral off, a data write also reaches its channel's output on the next cycle. While the enable is clear, every output presents the mid-scale code 0x800. The stored codes are kept, and they reappear when the enable is set again.

Top module: `dacbuf_top`

## Requirements
- R1: After reset, every held code is zero, the range selects and both control flags are zero, and every code output shows 0x800 because the enable is clear.
- R2: A write to offset 0x02 sets `dacEnable` from data bit 1 and `dacBuffered` from data bit 0. The new values are visible on the cycle after the write.
- R3: While `dacEnable` is 0, all four code outputs equal 0x800 whatever the held codes are.
- R4: With `dacBuffered` at 0, a write to offset 0x14 + 2·n (n = 0..3) places the data on channel n's output on the next cycle and leaves the other channels unchanged.
- R5: With `dacBuffered` at 1, a data write only updates the channel's preload register. No output changes until a commit.
- R6: A read of offset 0x02 copies all four preload registers to the held codes in one cycle, visible on the next cycle.
- R7: A write to offset 0x12 stages range bits without changing the selects. A read of 0x12 applies them: polarity of channel n comes from data bit 7−n and gain of channel n from data bit 11−n.
- R8: Data bits 15:12 of a channel write are discarded. Only bits 11:0 form the code.
- R9: In a cycle with both write and read enables asserted, only the write acts and no commit takes place.
- R10: A read of any offset other than 0x02 and 0x12 leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busRdEn | input | 1 | Read strobe for one cycle; commits at 0x02 and 0x12 |
| busAddr | input | 6 | Byte offset of the access |
| busWrData | input | 16 | Write data |
| dacCode | output | 48 | Four 12-bit converter codes, channel n in bits 12n+11:12n |
| dacBipolar | output | 4 | Applied polarity select per channel |
| dacGain | output | 4 | Applied gain select per channel |
| dacEnable | output | 1 | Global converter enable |
| dacBuffered | output | 1 | Deferred-update mode flag |

## Verification
A corrupted preload register stays hidden until the next commit read of 0x02. The bench therefore commits after every buffered sequence and checks all four channels on the following cycle. A stuck or miswired staging bit shows on the polarity or gain pin only on the cycle after a read of 0x12, so each range pattern is applied and read back at once. A wrong enable or mid-scale path changes all four codes together within one cycle of a control write. The bench checks this on both the clear and the set transitions.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  localparam int NUM_CH   = 4;
  localparam int DATA_W   = 12;
  localparam int BUS_W    = 16;
  localparam int ADDR_W   = 6;
  localparam logic [ADDR_W-1:0] OFS_CTRL2 = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_RANGE = 6'h12;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 6'h14;
  localparam int ENA_BIT  = 1;
  localparam int BUF_BIT  = 0;
  localparam int BIP_TOP  = 7;
  localparam int GAIN_TOP = 11;

  typedef struct packed {
    logic              wrCtrl2;
    logic              wrRange;
    logic [NUM_CH-1:0] wrChan;
    logic              applyRange;
    logic              commitAll;
  } strobe_t;
endpackage

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
  import dacbuf_pkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int AW    = ADDR_W
) (
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  output strobe_t       strobe
);
  logic rdOnly;
  logic [NCH-1:0] chanHit;

  // a write cycle wins over a read in the same cycle
  assign rdOnly = rdEn && !wrEn;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    localparam logic [AW-1:0] CH_OFS = AW'(OFS_DATA0 + 2 * ch);
    assign chanHit[ch] = (addr == CH_OFS);
  end

  always_comb begin
    strobe            = '0;
    strobe.wrCtrl2    = wrEn && (addr == OFS_CTRL2);
    strobe.wrRange    = wrEn && (addr == OFS_RANGE);
    strobe.wrChan     = wrEn ? chanHit : '0;
    strobe.applyRange = rdOnly && (addr == OFS_RANGE);
    strobe.commitAll  = rdOnly && (addr == OFS_CTRL2);
  end
endmodule

// File: rtl/dacbuf_datapath.sv
module dacbuf_datapath
  import dacbuf_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int BW  = BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [BW-1:0]    wrData,
  output logic [NCH*DW-1:0] dacCode,
  output logic [NCH-1:0]   dacBipolar,
  output logic [NCH-1:0]   dacGain,
  output logic             dacEnable,
  output logic             dacBuffered
);
  localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);

  logic           enaQ, bufQ;
  logic [NCH-1:0] stageBip, stageGain;
  logic [NCH-1:0] liveBip, liveGain;
  logic [DW-1:0]  newCode;

  assign newCode = wrData[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enaQ <= 1'b0;
      bufQ <= 1'b0;
    end else if (strobe.wrCtrl2) begin
      enaQ <= wrData[ENA_BIT];
      bufQ <= wrData[BUF_BIT];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] preQ, heldQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageBip[ch]  <= 1'b0;
        stageGain[ch] <= 1'b0;
        liveBip[ch]   <= 1'b0;
        liveGain[ch]  <= 1'b0;
      end else begin
        if (strobe.wrRange) begin
          stageBip[ch]  <= wrData[BIP_TOP - ch];
          stageGain[ch] <= wrData[GAIN_TOP - ch];
        end
        if (strobe.applyRange) begin
          liveBip[ch]  <= stageBip[ch];
          liveGain[ch] <= stageGain[ch];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        preQ  <= '0;
        heldQ <= '0;
      end else begin
        if (strobe.wrChan[ch]) preQ <= newCode;
        if (strobe.commitAll)
          heldQ <= preQ;
        else if (strobe.wrChan[ch] && !bufQ)
          heldQ <= newCode;
      end
    end

    assign dacCode[ch*DW +: DW] = enaQ ? heldQ : MID_CODE;
  end

  assign dacBipolar  = liveBip;
  assign dacGain     = liveGain;
  assign dacEnable   = enaQ;
  assign dacBuffered = bufQ;
endmodule

// File: rtl/dacbuf_top.sv
module dacbuf_top
  import dacbuf_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int BW  = BUS_W,
  parameter int AW  = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [AW-1:0]     busAddr,
  input  logic [BW-1:0]     busWrData,
  output logic [NCH*DW-1:0] dacCode,
  output logic [NCH-1:0]    dacBipolar,
  output logic [NCH-1:0]    dacGain,
  output logic              dacEnable,
  output logic              dacBuffered
);
  strobe_t strobe;

  dacbuf_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .wrEn  (busWrEn),
    .rdEn  (busRdEn),
    .addr  (busAddr),
    .strobe(strobe)
  );

  dacbuf_datapath #(.NCH(NCH), .DW(DW), .BW(BW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (busWrData),
    .dacCode    (dacCode),
    .dacBipolar (dacBipolar),
    .dacGain    (dacGain),
    .dacEnable  (dacEnable),
    .dacBuffered(dacBuffered)
  );
endmodule

// File: rtl/dacbuf_checker.sv
module dacbuf_checker
  import dacbuf_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int BW  = BUS_W,
  parameter int AW  = ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [AW-1:0]     busAddr,
  input logic [BW-1:0]     busWrData,
  input logic [NCH*DW-1:0] dacCode,
  input logic [NCH-1:0]    dacBipolar,
  input logic [NCH-1:0]    dacGain,
  input logic              dacEnable,
  input logic              dacBuffered
);
  localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);

  logic ctrl2Touch;
  assign ctrl2Touch = (busWrEn || busRdEn) && (busAddr == OFS_CTRL2);

  AST_CTRL2_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_CTRL2) |=>
      (dacEnable == $past(busWrData[ENA_BIT]) && dacBuffered == $past(busWrData[BUF_BIT]))); // R2

  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && !busWrEn && busAddr == OFS_RANGE) |=>
      ($stable(dacBipolar) && $stable(dacGain))); // R7

  AST_BUFFERED_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (dacBuffered && !ctrl2Touch) |=> $stable(dacCode)); // R5

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!dacBuffered && dacEnable && busWrEn && busAddr == OFS_DATA0) |=>
      (dacCode[DW-1:0] == $past(busWrData[DW-1:0]))); // R4

  for (genvar ch = 0; ch < NCH; ch++) begin : g_mid
    AST_MIDSCALE: assert property (@(posedge clk) disable iff (!rstN)
      !dacEnable |-> (dacCode[ch*DW +: DW] == MID_CODE)); // R3
  end
endmodule

bind dacbuf_top dacbuf_checker #(.NCH(NCH), .DW(DW), .BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .dacCode(dacCode),
  .dacBipolar(dacBipolar), .dacGain(dacGain), .dacEnable(dacEnable),
  .dacBuffered(dacBuffered)
);

// File: tb/dacbuf_top_tb.sv
module dacbuf_top_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn, busRdEn;
  logic [5:0]  busAddr;
  logic [15:0] busWrData;
  logic [47:0] dacCode;
  logic [3:0]  dacBipolar, dacGain;
  logic        dacEnable, dacBuffered;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dacbuf_top u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .dacCode(dacCode),
    .dacBipolar(dacBipolar), .dacGain(dacGain), .dacEnable(dacEnable),
    .dacBuffered(dacBuffered)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkCodes(input string req, input logic [11:0] c0, input logic [11:0] c1,
                            input logic [11:0] c2, input logic [11:0] c3);
    check(req, 32'(dacCode[11:0]),  32'(c0));
    check(req, 32'(dacCode[23:12]), 32'(c1));
    check(req, 32'(dacCode[35:24]), 32'(c2));
    check(req, 32'(dacCode[47:36]), 32'(c3));
  endtask

  // drive on falling edge; result is sampled on the next falling edge
  task automatic access(input logic wr, input logic rd, input logic [5:0] a, input logic [15:0] d);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    checkCodes("R1", 12'h800, 12'h800, 12'h800, 12'h800);
    check("R1", 32'({dacBipolar, dacGain, dacEnable, dacBuffered}), 32'h0);
  endtask

  task automatic tDirect();
    access(1, 0, 6'h02, 16'h0002);
    check("R2", 32'({dacEnable, dacBuffered}), 32'b10);
    checkCodes("R1", 12'h000, 12'h000, 12'h000, 12'h000);
    access(1, 0, 6'h14, 16'hF123);
    checkCodes("R4 R8", 12'h123, 12'h000, 12'h000, 12'h000);
    access(1, 0, 6'h18, 16'h0ABC);
    checkCodes("R4", 12'h123, 12'h000, 12'hABC, 12'h000);
  endtask

  task automatic tBuffered();
    access(1, 0, 6'h02, 16'h0003);
    check("R2", 32'({dacEnable, dacBuffered}), 32'b11);
    access(1, 0, 6'h14, 16'h0111);
    access(1, 0, 6'h16, 16'hA222);
    access(1, 0, 6'h1A, 16'h0333);
    checkCodes("R5", 12'h123, 12'h000, 12'hABC, 12'h000);
    access(0, 1, 6'h04, 16'h0000);
    access(0, 1, 6'h14, 16'h0000);
    checkCodes("R10", 12'h123, 12'h000, 12'hABC, 12'h000);
    access(0, 1, 6'h02, 16'h0000);
    checkCodes("R6 R8", 12'h111, 12'h222, 12'hABC, 12'h333);
  endtask

  task automatic tRange();
    // bipolar ch0 (bit7), ch2 (bit5); gain ch3 (bit8)
    access(1, 0, 6'h12, 16'h01A0);
    check("R7", 32'({dacBipolar, dacGain}), 32'h00);
    access(0, 1, 6'h02, 16'h0000);
    check("R7", 32'({dacBipolar, dacGain}), 32'h00);
    access(0, 1, 6'h12, 16'h0000);
    check("R7", 32'(dacBipolar), 32'b0101);
    check("R7", 32'(dacGain), 32'b1000);
    // gain ch0 (bit11), bipolar ch3 (bit4)
    access(1, 0, 6'h12, 16'h0810);
    check("R7", 32'({dacBipolar, dacGain}), 32'h58);
    access(0, 1, 6'h12, 16'h0000);
    check("R7", 32'(dacBipolar), 32'b1000);
    check("R7", 32'(dacGain), 32'b0001);
  endtask

  task automatic tCollide();
    access(1, 0, 6'h16, 16'h0555);
    access(1, 1, 6'h02, 16'h0003);
    checkCodes("R9", 12'h111, 12'h222, 12'hABC, 12'h333);
    access(0, 1, 6'h02, 16'h0000);
    checkCodes("R6", 12'h111, 12'h555, 12'hABC, 12'h333);
  endtask

  task automatic tDisable();
    access(1, 0, 6'h02, 16'h0001);
    check("R2", 32'({dacEnable, dacBuffered}), 32'b01);
    checkCodes("R3", 12'h800, 12'h800, 12'h800, 12'h800);
    access(1, 0, 6'h02, 16'h0003);
    checkCodes("R3", 12'h111, 12'h555, 12'hABC, 12'h333);
  endtask

  initial begin
    busWrEn = 0; busRdEn = 0; busAddr = '0; busWrData = '0; rstN = 0;
    @(negedge clk);
    tReset();
    tDirect();
    tBuffered();
    tRange();
    tCollide();
    tDisable();
    tReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule